// File: doc/BRIEF.md
# RTC Interrupt Controller

This block produces the active-low interrupt request of a real-time clock from three maskable sources: a programmable periodic timer, a time-of-day alarm, and a power-fail event. A fourth flag, the watchdog timeout flag, is captured from an external watchdog counter and can be read back, but it does not drive the interrupt. Every event sets its own flag whether or not that source is enabled. The interrupt goes low only when a set flag has its enable bit set.

A host writes a control byte that holds the rate code and the enable bits, and four alarm bytes. In each alarm byte, bit 7 is a "don't care" mask and bits 6:0 hold the BCD value. The flag byte is always visible on `flags_o`. A read of the flags address clears every flag, but only after that read has been held for a programmable number of clock cycles. The periodic timer is driven by a strobe at 32768 Hz. The alarm is compared against the current BCD time on each once-per-second update strobe.

Register map: address 0 holds the flags (read to clear) and address 1 the control byte. Addresses 2, 3, 4 and 5 hold the alarm seconds, minutes, hours and date. Control byte: bits 3:0 rate code, bit 4 periodic enable, bit 5 alarm enable, bit 6 power-fail enable, bit 7 backup-alarm enable. Flag byte: bit 0 watchdog, bit 1 periodic, bit 2 power-fail, bit 3 alarm; bits 7:4 read as 0.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: With rate code 0 the periodic flag is never set, however many ticks arrive.
- R2: With a rate code k from 3 to 15, the periodic flag sets on every tick whose index, counted from reset, is a multiple of 2^(k-1). Code 3 therefore gives 4 ticks (about 122 µs) and code 15 gives 16384 ticks (500 ms).
- R3: Rate code 1 sets the periodic flag on every multiple of HUND_TICKS ticks (the 10 ms rate). Rate code 2 sets it on every multiple of 10*HUND_TICKS ticks (the 100 ms rate). Both are counted from reset.
- R4: The alarm flag is set only on an update strobe. It is set when every alarm field whose bit 7 is clear equals the matching time input in bits 6:0. Mask patterns (date,hour,min,sec) 1111, 1110, 1100, 1000 and 0000 give alarms once per second, per minute, per hour, per day, and on a full date match.
- R5: A flag is set even when its enable is clear. Outside battery backup, `irq_no` is low exactly when at least one of the periodic, alarm or power-fail flags is set together with its enable bit.
- R6: A read of address 0 held for HOLD_CYCLES consecutive cycles clears all flags once, which releases `irq_no`. A shorter read changes nothing.
- R7: After reset the flags are 0, all enables are 0, and `irq_no` is high.
- R8: While `bat_i` is high, `irq_no` is low only if the alarm flag, the alarm enable and the backup-alarm enable are all set.
- R9: A rising edge on `pf_i` sets the power-fail flag.
- R10: A pulse on `wd_evt_i` sets the watchdog flag, and this flag never drives `irq_no`.
- R11: An event that arrives in the same cycle as a clear leaves its flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 3 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read select |
| wdata_i | input | 8 | Write data |
| tick_i | input | 1 | 32768 Hz tick strobe |
| upd_i | input | 1 | Once-per-second time update strobe |
| time_sec_i | input | 7 | Current seconds, BCD |
| time_min_i | input | 7 | Current minutes, BCD |
| time_hour_i | input | 7 | Current hours, BCD |
| time_date_i | input | 7 | Current date, BCD |
| pf_i | input | 1 | Supply failure detected |
| bat_i | input | 1 | Battery-backup mode |
| wd_evt_i | input | 1 | Watchdog timeout pulse |
| flags_o | output | 8 | Flag byte |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
The bench builds the block with HUND_TICKS=5 and HOLD_CYCLES=3. With these values the 10 ms and 100 ms rates fall due after 5 and 50 ticks, so their exact tick boundaries can be checked along with the binary codes up to the 16384-tick rate. The short hold also makes it cheap to probe the read-clear boundary with a read that is one cycle too short. It also makes it possible to land an alarm update exactly on the clearing cycle.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int PER_DIV_W = 14;
  localparam int RATE_MAX  = 15;
  localparam int N_FLAGS   = 4;
  localparam int N_ALM     = 4;

  localparam int FLG_WD  = 0;
  localparam int FLG_PER = 1;
  localparam int FLG_PF  = 2;
  localparam int FLG_ALM = 3;

  localparam logic [2:0] ADDR_FLAGS = 3'd0;
  localparam logic [2:0] ADDR_CTRL  = 3'd1;
  localparam logic [2:0] ADDR_ALM0  = 3'd2;

  typedef struct packed {
    logic       bk_alm_en;
    logic       pf_en;
    logic       alm_en;
    logic       per_en;
    logic [3:0] rate;
  } ctrl_t;
endpackage

// File: rtl/rtc_rate_gen.sv
module rtc_rate_gen
  import rtc_irq_pkg::*;
#(
  parameter int HUND_TICKS = 328
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [3:0] rate_i,
  output logic       per_evt_o
);
  localparam int HW = $clog2(HUND_TICKS);
  localparam logic [HW-1:0] HUND_LAST = HW'(HUND_TICKS - 1);

  logic [PER_DIV_W-1:0] bin_cnt_q;
  logic [HW-1:0]        hund_cnt_q;
  logic [3:0]           tenth_cnt_q;
  logic [RATE_MAX:0]    bin_evt;
  logic                 hund_evt, tenth_evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bin_cnt_q <= '0;
    else if (tick_i) bin_cnt_q <= bin_cnt_q + 1'b1;
  end

  // code k fires when the low k-1 divider bits roll over
  assign bin_evt[2:0] = '0;
  for (genvar g = 3; g <= RATE_MAX; g++) begin : g_bin
    assign bin_evt[g] = &bin_cnt_q[g-2:0];
  end

  assign hund_evt  = tick_i && (hund_cnt_q == HUND_LAST);
  assign tenth_evt = hund_evt && (tenth_cnt_q == 4'd9);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hund_cnt_q  <= '0;
      tenth_cnt_q <= '0;
    end else if (tick_i) begin
      hund_cnt_q <= hund_evt ? '0 : hund_cnt_q + 1'b1;
      if (hund_evt) tenth_cnt_q <= tenth_evt ? 4'd0 : tenth_cnt_q + 4'd1;
    end
  end

  always_comb begin
    case (rate_i)
      4'd0:    per_evt_o = 1'b0;
      4'd1:    per_evt_o = hund_evt;
      4'd2:    per_evt_o = tenth_evt;
      default: per_evt_o = tick_i && bin_evt[rate_i];
    endcase
  end

  AST_HUND_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hund_cnt_q <= HUND_LAST); // R3
  AST_TENTH_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tenth_cnt_q <= 4'd9); // R3
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_irq_pkg::*;
(
  input  logic [N_ALM-1:0][7:0] alm_i,
  input  logic [N_ALM-1:0][6:0] now_i,
  output logic                  match_o
);
  logic [N_ALM-1:0] hit;

  for (genvar i = 0; i < N_ALM; i++) begin : g_fld
    assign hit[i] = alm_i[i][7] || (alm_i[i][6:0] == now_i[i]);
  end

  assign match_o = &hit;
endmodule

// File: rtl/rtc_flag_clr.sv
module rtc_flag_clr #(
  parameter int HOLD_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_sel_i,
  output logic clr_o
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] HOLD_MAX = CW'(HOLD_CYCLES);

  logic [CW-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= '0;
    else if (!rd_sel_i) hold_q <= '0;
    else if (hold_q != HOLD_MAX) hold_q <= hold_q + 1'b1;
  end

  assign clr_o = rd_sel_i && (hold_q == HOLD_MAX - 1'b1);

  AST_CLR_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |=> !clr_o); // R6
  AST_CLR_NEEDS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_sel_i |-> !clr_o); // R6
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
#(
  parameter int HUND_TICKS  = 328,
  parameter int HOLD_CYCLES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] addr_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [7:0] wdata_i,
  input  logic       tick_i,
  input  logic       upd_i,
  input  logic [6:0] time_sec_i,
  input  logic [6:0] time_min_i,
  input  logic [6:0] time_hour_i,
  input  logic [6:0] time_date_i,
  input  logic       pf_i,
  input  logic       bat_i,
  input  logic       wd_evt_i,
  output logic [7:0] flags_o,
  output logic       irq_no
);
  ctrl_t                  ctrl_q;
  logic [N_ALM-1:0][7:0]  alm_q;
  logic [N_ALM-1:0][6:0]  now;
  logic [N_FLAGS-1:0]     flags_q, evt;
  logic                   pf_q, per_evt, alm_match, clr, irq_req;

  assign now = {time_date_i, time_hour_i, time_min_i, time_sec_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      alm_q  <= '0;
    end else if (wr_i) begin
      if (addr_i == ADDR_CTRL) ctrl_q <= ctrl_t'(wdata_i);
      for (int i = 0; i < N_ALM; i++)
        if (addr_i == ADDR_ALM0 + 3'(i)) alm_q[i] <= wdata_i;
    end
  end

  rtc_rate_gen #(.HUND_TICKS(HUND_TICKS)) u_rate (
    .clk_i, .rst_ni, .tick_i, .rate_i(ctrl_q.rate), .per_evt_o(per_evt)
  );

  rtc_alarm_match u_alm (.alm_i(alm_q), .now_i(now), .match_o(alm_match));

  rtc_flag_clr #(.HOLD_CYCLES(HOLD_CYCLES)) u_clr (
    .clk_i, .rst_ni, .rd_sel_i(rd_i && addr_i == ADDR_FLAGS), .clr_o(clr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pf_q <= 1'b0;
    else         pf_q <= pf_i;
  end

  always_comb begin
    evt          = '0;
    evt[FLG_WD]  = wd_evt_i;
    evt[FLG_PER] = per_evt;
    evt[FLG_PF]  = pf_i && !pf_q;
    evt[FLG_ALM] = upd_i && alm_match;
  end

  // a new event outranks a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= evt | (flags_q & {N_FLAGS{!clr}});
  end

  always_comb begin
    if (bat_i)
      irq_req = ctrl_q.bk_alm_en && ctrl_q.alm_en && flags_q[FLG_ALM];
    else
      irq_req = (ctrl_q.per_en && flags_q[FLG_PER]) ||
                (ctrl_q.alm_en && flags_q[FLG_ALM]) ||
                (ctrl_q.pf_en  && flags_q[FLG_PF]);
  end

  assign irq_no  = !irq_req;
  assign flags_o = {{(8-N_FLAGS){1'b0}}, flags_q};

  AST_NO_EN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.per_en && !ctrl_q.alm_en && !ctrl_q.pf_en) |-> irq_no); // R5
  AST_BACKUP_ALARM_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bat_i && !flags_o[FLG_ALM]) |-> irq_no); // R8
  AST_CLR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && evt == '0) |=> flags_o == 8'h00); // R6
  AST_PF_EDGE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pf_i) |=> flags_o[FLG_PF]); // R9
  AST_ALARM_ON_UPD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_i && !clr) |=> flags_o[FLG_ALM] == $past(flags_o[FLG_ALM])); // R4
  AST_WD_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o[2:1] == 2'b00 && !flags_o[FLG_ALM]) |-> irq_no); // R10
endmodule

// File: tb/rtc_irq_ctrl_bench.sv
module rtc_irq_ctrl_bench;
  localparam int HUND = 5;
  localparam int HOLD = 3;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic [2:0] addr_i = '0;
  logic       wr_i = 1'b0, rd_i = 1'b0, tick_i = 1'b0, upd_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [6:0] time_sec_i = '0, time_min_i = '0, time_hour_i = '0, time_date_i = '0;
  logic       pf_i = 1'b0, bat_i = 1'b0, wd_evt_i = 1'b0;
  logic [7:0] flags_o;
  logic       irq_no;

  int n_chk = 0, n_bad = 0;
  longint tick_total = 0;
  bit done = 0;

  rtc_irq_ctrl #(.HUND_TICKS(HUND), .HOLD_CYCLES(HOLD)) u_rtc_irq_ctrl (.*);

  always #10 clk_i = ~clk_i;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic rd_hold(int n);
    @(negedge clk_i); addr_i = 3'd0; rd_i = 1'b1;
    repeat (n) @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic ticks(longint n);
    if (n > 0) begin
      @(negedge clk_i); tick_i = 1'b1;
      repeat (n) @(negedge clk_i);
      tick_i = 1'b0;
      tick_total += n;
    end
  endtask

  task automatic upd_pulse();
    @(negedge clk_i); upd_i = 1'b1;
    @(negedge clk_i); upd_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R7 flags", flags_o, 8'h00);
    check("R7 irq", irq_no, 1'b1);
    upd_pulse();
    check("R7 enables clear: alarm flag without irq", {flags_o, 7'd0, irq_no}, {8'h08, 8'h01});
    rd_hold(HOLD);
  endtask

  task automatic t_rate_off();
    wr(3'd1, 8'h10);
    rd_hold(HOLD);
    ticks(64);
    check("R1 rate 0 flag", flags_o[1], 1'b0);
    check("R1 rate 0 irq", irq_no, 1'b1);
  endtask

  task automatic rate_check(string req, int code, longint p);
    longint pre;
    wr(3'd1, 8'h10 | 8'(code));
    rd_hold(HOLD);
    pre = p - 1 - (tick_total % p);
    ticks(pre);
    check({req, " before boundary"}, flags_o[1], 1'b0);
    ticks(1);
    check({req, " at boundary"}, flags_o[1], 1'b1);
    check({req, " irq"}, irq_no, 1'b0);
  endtask

  task automatic t_rate_bin();
    rate_check("R2 code3", 3, 4);
    rate_check("R2 code4", 4, 8);
    rate_check("R2 code7", 7, 64);
    rate_check("R2 code15", 15, 16384);
  endtask

  task automatic t_rate_dec();
    rate_check("R3 code1", 1, HUND);
    rate_check("R3 code1 again", 1, HUND);
    rate_check("R3 code2", 2, 10 * HUND);
  endtask

  task automatic alarm_case(string req, logic [3:0] m, logic [6:0] ad, ah, am, as, logic exp);
    wr(3'd1, 8'h00);
    wr(3'd2, {m[0], as});
    wr(3'd3, {m[1], am});
    wr(3'd4, {m[2], ah});
    wr(3'd5, {m[3], ad});
    @(negedge clk_i);
    time_sec_i = 7'h45; time_min_i = 7'h30; time_hour_i = 7'h12; time_date_i = 7'h15;
    rd_hold(HOLD);
    repeat (2) @(negedge clk_i);
    check({req, " no strobe"}, flags_o[3], 1'b0);
    upd_pulse();
    check(req, flags_o[3], exp);
  endtask

  task automatic t_alarm();
    alarm_case("R4 1111 every second", 4'hF, 7'h01, 7'h02, 7'h03, 7'h04, 1'b1);
    alarm_case("R4 1110 sec match", 4'hE, 7'h01, 7'h02, 7'h03, 7'h45, 1'b1);
    alarm_case("R4 1110 sec miss", 4'hE, 7'h15, 7'h12, 7'h30, 7'h46, 1'b0);
    alarm_case("R4 1100 hourly", 4'hC, 7'h01, 7'h02, 7'h30, 7'h45, 1'b1);
    alarm_case("R4 1000 daily", 4'h8, 7'h01, 7'h12, 7'h30, 7'h45, 1'b1);
    alarm_case("R4 1000 hour miss", 4'h8, 7'h15, 7'h13, 7'h30, 7'h45, 1'b0);
    alarm_case("R4 0000 full match", 4'h0, 7'h15, 7'h12, 7'h30, 7'h45, 1'b1);
    alarm_case("R4 0000 date miss", 4'h0, 7'h16, 7'h12, 7'h30, 7'h45, 1'b0);
  endtask

  task automatic t_gate();
    alarm_case("R5 flag without enable", 4'hF, 7'h0, 7'h0, 7'h0, 7'h0, 1'b1);
    check("R5 irq masked", irq_no, 1'b1);
    wr(3'd1, 8'h20);
    check("R5 irq enabled alarm", irq_no, 1'b0);
    wr(3'd1, 8'h50);
    check("R5 other enables only", irq_no, 1'b1);
  endtask

  task automatic t_clear();
    wr(3'd1, 8'h20);
    rd_hold(HOLD - 1);
    check("R6 short read keeps flags", flags_o, 8'h08);
    check("R6 short read keeps irq", irq_no, 1'b0);
    rd_hold(HOLD);
    check("R6 full read clears", flags_o, 8'h00);
    check("R6 irq released", irq_no, 1'b1);
  endtask

  task automatic t_pf();
    wr(3'd1, 8'h40);
    @(negedge clk_i); pf_i = 1'b1;
    @(negedge clk_i);
    check("R9 pf flag", flags_o[2], 1'b1);
    check("R9 pf irq", irq_no, 1'b0);
    rd_hold(HOLD);
    check("R9 level alone does not re-set", flags_o[2], 1'b0);
    @(negedge clk_i); pf_i = 1'b0;
  endtask

  task automatic t_wd();
    wr(3'd1, 8'hF0);
    @(negedge clk_i); wd_evt_i = 1'b1;
    @(negedge clk_i); wd_evt_i = 1'b0;
    check("R10 wd flag", flags_o, 8'h01);
    check("R10 wd no irq", irq_no, 1'b1);
    rd_hold(HOLD);
  endtask

  task automatic t_backup();
    alarm_case("R8 alarm set", 4'hF, 7'h0, 7'h0, 7'h0, 7'h0, 1'b1);
    @(negedge clk_i); pf_i = 1'b1;
    @(negedge clk_i); pf_i = 1'b0; bat_i = 1'b1;
    wr(3'd1, 8'h60);
    check("R8 backup without bk enable", irq_no, 1'b1);
    wr(3'd1, 8'hE0);
    check("R8 backup alarm drives", irq_no, 1'b0);
    wr(3'd1, 8'hC0);
    check("R8 needs alarm enable", irq_no, 1'b1);
    @(negedge clk_i); bat_i = 1'b0;
    @(negedge clk_i);
    check("R8 normal mode pf irq returns", irq_no, 1'b0);
    rd_hold(HOLD);
  endtask

  task automatic t_coincide();
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h80); wr(3'd3, 8'h80); wr(3'd4, 8'h80); wr(3'd5, 8'h80);
    @(negedge clk_i); wd_evt_i = 1'b1;
    @(negedge clk_i); wd_evt_i = 1'b0;
    @(negedge clk_i); addr_i = 3'd0; rd_i = 1'b1;
    repeat (HOLD - 1) @(negedge clk_i);
    upd_i = 1'b1;
    @(negedge clk_i); upd_i = 1'b0; rd_i = 1'b0;
    check("R11 event beats clear", flags_o, 8'h08);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_rate_off();
    t_rate_bin();
    t_rate_dec();
    t_alarm();
    t_gate();
    t_clear();
    t_pf();
    t_wd();
    t_backup();
    t_coincide();
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule